// File: doc/BRIEF.md
# Dual Cascadable Conversion Sequencer

This block steps a single external analog converter through a programmed list of conversion slots. The list is sixteen slots long. It can run as two independent sequencers of eight slots each, with the lower half owned by the first sequencer and the upper half by the second. It can also run as one sequencer that walks all sixteen slots. Each slot names a 4-bit input channel. A channel may appear in several slots or in none. Each completed slot writes its 12-bit result into the result register with the same index. Every result register is presented in two views: left-justified and right-justified.

A start trigger launches the whole programmed list of a sequencer. When the list ends, the sequencer raises a one-cycle end-of-sequence pulse and a sticky interrupt flag. It then either stops until the next trigger or restarts on its own, depending on the continuous-mode setting. In paired mode, each slot selects a matching A/B channel pair. Both values come back from one conversion and land in two adjacent result registers. A fixed-priority arbiter hands the converter to one sequencer at a time. The converter itself is outside the block and uses a start/done handshake.

Top module: `adc_seq_ctrl`

## Requirements
- R1: In dual mode (cascade=0), a trigger of sequencer 1 converts slots 0 up to cnt_max1[2:0] in order. Slot k's result is written to result register k. Register k occupies bits [16k+15:16k] of each result bus.
- R2: Counts are stored minus one. A count field of 0 gives exactly one conversion per sequence.
- R3: With cascade=1, sequencer 1 walks slots 0 up to cnt_max1 (up to 16 slots). Its end of sequence appears on bit 0. Triggers on seq2_trig have no effect.
- R4: In dual mode, sequencer 2 converts slots 8 up to 8+cnt_max2 into result registers 8 onward. It signals on bit 1.
- R5: conv_chan carries the slot's 4-bit channel unchanged in non-paired mode, so a channel may repeat across slots. Slot k's channel is slot_chan[4k+3:4k].
- R6: res_left presents each 12-bit result in bits [15:4] with zeros below. res_right presents the same result in bits [11:0] with zeros above.
- R7: Any bit of a sequencer's trigger vector starts the whole list. Triggers that arrive while that sequencer is busy are ignored.
- R8: Completing the last slot gives a one-cycle eos_pulse on the owning sequencer's bit, in the same cycle as the final conv_done.
- R9: With run_cont=0, a sequencer stops after its end of sequence. With run_cont=1, it restarts the list with no new trigger. Clearing run_cont ends the run at the next end of sequence.
- R10: With pair_mode=1, conv_pair is high and conv_chan is the slot channel's low 3 bits (pair index). Conversion i of a sequence with base b writes conv_data_a to register b+2i and conv_data_b to register b+2i+1.
- R11: When both sequencers request the converter in the same cycle, sequencer 1 runs its full list first.
- R12: irq_flag[s] sets on end of sequence and holds until irq_clr[s] is pulsed. An end of sequence while the flag is already set raises irq_ovf[s], which also clears with irq_clr[s].
- R13: Synchronous active-low reset leaves both sequencers idle. It also clears conv_start, every flag and every result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cascade | input | 1 | 1 joins both sequencers into one 16-slot list |
| pair_mode | input | 1 | 1 selects paired A/B sampling |
| run_cont | input | 1 | 1 restarts the list automatically |
| cnt_max1 | input | 4 | Sequencer 1 conversion count minus one |
| cnt_max2 | input | 3 | Sequencer 2 conversion count minus one |
| slot_chan | input | 64 | Sixteen 4-bit slot channel numbers |
| seq1_trig | input | 4 | Sequencer 1 start sources |
| seq2_trig | input | 2 | Sequencer 2 start sources |
| irq_clr | input | 2 | Write-one clear of flag and overflow per sequencer |
| conv_done | input | 1 | Converter done strobe with data valid |
| conv_data_a | input | 12 | Converter result, A side |
| conv_data_b | input | 12 | Converter result, B side (paired mode) |
| conv_start | output | 1 | One-cycle start of conversion |
| conv_pair | output | 1 | Converter should sample a pair |
| conv_chan | output | 4 | Channel or pair index for the conversion |
| res_left | output | 256 | Sixteen left-justified 16-bit results |
| res_right | output | 256 | Sixteen right-justified 16-bit results |
| eos_pulse | output | 2 | End-of-sequence pulse per sequencer |
| irq_flag | output | 2 | Sticky end-of-sequence flags |
| irq_ovf | output | 2 | Flag overflow status |

## Verification
The bench drives a count field of zero to catch an off-by-one count that would run two conversions or none. It pulses both sequencers in the same cycle to expose a priority inversion or an interleaving of slots. It re-triggers a sequencer that is already busy, which would restart the list or skew the result indices in a design lacking the busy guard. Paired mode is checked for results landing at b+2i rather than b+i. Continuous mode is stopped mid-run to show whether an extra sequence is issued. A second end of sequence before any clear must raise overflow, and a trigger on the second sequencer in cascaded mode must not steal the upper slots.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W = 12;
  localparam int OUT_W = 16;

  typedef enum logic [1:0] {ST_FREE, ST_START, ST_WAIT} eng_state_e;

  function automatic logic [OUT_W-1:0] f_left(logic [RES_W-1:0] v);
    return {v, 4'h0};
  endfunction

  function automatic logic [OUT_W-1:0] f_right(logic [RES_W-1:0] v);
    return {4'h0, v};
  endfunction

  // result register for conversion cnt; paired mode spreads A/B over two entries
  function automatic logic [15:0] f_res_index(logic [15:0] base, logic [15:0] cnt,
                                              logic [15:0] mask, logic paired, logic hi);
    if (paired) return base + (((cnt << 1) | {15'd0, hi}) & mask);
    return base + cnt;
  endfunction
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_any,
  input  logic enable,
  input  logic finish,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (!rst_n)                         busy <= 1'b0;
    else if (!busy && trig_any && enable) busy <= 1'b1;
    else if (finish)                    busy <= 1'b0;
  end
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int CH_W  = 4,
  localparam int TOT   = 2 * SLOTS,
  localparam int PTR_W = $clog2(TOT),
  localparam int LOC_W = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cascade,
  input  logic                  paired,
  input  logic [1:0]            act,
  input  logic [PTR_W-1:0]      max1,
  input  logic [LOC_W-1:0]      max2,
  input  logic [TOT*CH_W-1:0]   slot_chan,
  input  logic                  conv_done,
  output logic                  conv_start,
  output logic                  conv_pair,
  output logic [CH_W-1:0]       conv_chan,
  output logic                  wr_en,
  output logic [PTR_W-1:0]      wr_idx_a,
  output logic [PTR_W-1:0]      wr_idx_b,
  output logic [1:0]            eos
);
  eng_state_e        state_q;
  logic              owner_q;
  logic [PTR_W-1:0]  cnt_q;

  logic [1:0]        req;
  logic              grant_fire, grant_sel;
  logic [PTR_W-1:0]  base, last, slot, span_mask;
  logic [CH_W-1:0]   ch;
  logic              done_evt, last_hit;

  assign req        = cascade ? {1'b0, act[0]} : act;
  assign grant_fire = (state_q == ST_FREE) && (|req);
  assign grant_sel  = ~req[0];

  assign base      = owner_q ? PTR_W'(SLOTS) : '0;
  assign last      = cascade ? max1 : (owner_q ? PTR_W'(max2) : PTR_W'(max1[LOC_W-1:0]));
  assign slot      = base + cnt_q;
  assign span_mask = cascade ? PTR_W'(TOT - 1) : PTR_W'(SLOTS - 1);
  assign ch        = slot_chan[slot*CH_W +: CH_W];

  assign conv_start = (state_q == ST_START);
  assign conv_pair  = paired;
  assign conv_chan  = paired ? {1'b0, ch[CH_W-2:0]} : ch;

  assign done_evt = (state_q == ST_WAIT) && conv_done;
  assign last_hit = (cnt_q == last);
  assign wr_en    = done_evt;
  assign wr_idx_a = PTR_W'(f_res_index(16'(base), 16'(cnt_q), 16'(span_mask), paired, 1'b0));
  assign wr_idx_b = PTR_W'(f_res_index(16'(base), 16'(cnt_q), 16'(span_mask), paired, 1'b1));
  assign eos      = {done_evt && last_hit && owner_q, done_evt && last_hit && !owner_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FREE;
      owner_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_FREE: if (grant_fire) begin
          owner_q <= grant_sel;
          cnt_q   <= '0;
          state_q <= ST_START;
        end
        ST_START: state_q <= ST_WAIT;
        ST_WAIT: if (conv_done) begin
          if (last_hit) state_q <= ST_FREE;
          else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_START;
          end
        end
        default: state_q <= ST_FREE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results
  import adc_seq_pkg::*;
#(
  parameter int TOT = 16,
  localparam int PTR_W = $clog2(TOT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_b,
  input  logic [PTR_W-1:0]     idx_a,
  input  logic [PTR_W-1:0]     idx_b,
  input  logic [RES_W-1:0]     data_a,
  input  logic [RES_W-1:0]     data_b,
  output logic [TOT*OUT_W-1:0] res_left,
  output logic [TOT*OUT_W-1:0] res_right
);
  for (genvar i = 0; i < TOT; i++) begin : g_reg
    logic [RES_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                     r_q <= '0;
      else if (wr_en && idx_a == PTR_W'(i))           r_q <= data_a;
      else if (wr_en && wr_b && idx_b == PTR_W'(i))   r_q <= data_b;
    end
    assign res_left[i*OUT_W +: OUT_W]  = f_left(r_q);
    assign res_right[i*OUT_W +: OUT_W] = f_right(r_q);
  end
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic eos,
  input  logic clr,
  output logic flag,
  output logic ovf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      flag <= eos | (flag & ~clr);
      ovf  <= clr ? 1'b0 : (ovf | (eos & flag));
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int CH_W  = 4,
  localparam int TOT   = 2 * SLOTS,
  localparam int PTR_W = $clog2(TOT),
  localparam int LOC_W = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cascade,
  input  logic                  pair_mode,
  input  logic                  run_cont,
  input  logic [PTR_W-1:0]      cnt_max1,
  input  logic [LOC_W-1:0]      cnt_max2,
  input  logic [TOT*CH_W-1:0]   slot_chan,
  input  logic [3:0]            seq1_trig,
  input  logic [1:0]            seq2_trig,
  input  logic [1:0]            irq_clr,
  input  logic                  conv_done,
  input  logic [RES_W-1:0]      conv_data_a,
  input  logic [RES_W-1:0]      conv_data_b,
  output logic                  conv_start,
  output logic                  conv_pair,
  output logic [CH_W-1:0]       conv_chan,
  output logic [TOT*OUT_W-1:0]  res_left,
  output logic [TOT*OUT_W-1:0]  res_right,
  output logic [1:0]            eos_pulse,
  output logic [1:0]            irq_flag,
  output logic [1:0]            irq_ovf
);
  logic [1:0]       act, trig_any, trig_en, finish;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx_a, wr_idx_b;

  assign trig_any = {|seq2_trig, |seq1_trig};
  assign trig_en  = {~cascade, 1'b1};
  assign finish   = eos_pulse & {2{~run_cont}};

  for (genvar s = 0; s < 2; s++) begin : g_seq
    adc_seq_trig u_trig (
      .clk(clk), .rst_n(rst_n), .trig_any(trig_any[s]), .enable(trig_en[s]),
      .finish(finish[s]), .busy(act[s])
    );
    adc_seq_irq u_irq (
      .clk(clk), .rst_n(rst_n), .eos(eos_pulse[s]), .clr(irq_clr[s]),
      .flag(irq_flag[s]), .ovf(irq_ovf[s])
    );
  end

  adc_seq_engine #(.SLOTS(SLOTS), .CH_W(CH_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cascade(cascade), .paired(pair_mode), .act(act),
    .max1(cnt_max1), .max2(cnt_max2), .slot_chan(slot_chan), .conv_done(conv_done),
    .conv_start(conv_start), .conv_pair(conv_pair), .conv_chan(conv_chan),
    .wr_en(wr_en), .wr_idx_a(wr_idx_a), .wr_idx_b(wr_idx_b), .eos(eos_pulse)
  );

  adc_seq_results #(.TOT(TOT)) u_res (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_b(pair_mode),
    .idx_a(wr_idx_a), .idx_b(wr_idx_b), .data_a(conv_data_a), .data_b(conv_data_b),
    .res_left(res_left), .res_right(res_right)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cascade,
  input logic       conv_start,
  input logic [1:0] eos_pulse,
  input logic [1:0] irq_flag,
  input logic [1:0] irq_ovf,
  input logic [1:0] irq_clr,
  input logic [1:0] act,
  input logic       grant_fire,
  input logic       grant_sel
);
  a_r13_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq_flag == 2'b00 && irq_ovf == 2'b00 && !conv_start));

  a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r8_eos_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eos_pulse));

  a_r8_eos_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eos_pulse[0] |=> !eos_pulse[0]);

  a_r3_casc_no_seq2: assert property (@(posedge clk) disable iff (!rst_n)
    cascade |-> !eos_pulse[1]);

  a_r11_seq1_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fire && act == 2'b11) |-> !grant_sel);

  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag[0] && !irq_clr[0]) |=> irq_flag[0]);

  a_r12_ovf_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovf[1]) |-> $past(irq_flag[1]));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cascade(cascade), .conv_start(conv_start),
  .eos_pulse(eos_pulse), .irq_flag(irq_flag), .irq_ovf(irq_ovf), .irq_clr(irq_clr),
  .act(act), .grant_fire(u_eng.grant_fire), .grant_sel(u_eng.grant_sel)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cascade = 1'b0, pair_mode = 1'b0, run_cont = 1'b0;
  logic [3:0]   cnt_max1 = '0;
  logic [2:0]   cnt_max2 = '0;
  logic [63:0]  slot_chan = '0;
  logic [3:0]   seq1_trig = '0;
  logic [1:0]   seq2_trig = '0;
  logic [1:0]   irq_clr = '0;
  logic         conv_done = 1'b0;
  logic [11:0]  conv_data_a = '0, conv_data_b = '0;
  logic         conv_start, conv_pair;
  logic [3:0]   conv_chan;
  logic [255:0] res_left, res_right;
  logic [1:0]   eos_pulse, irq_flag, irq_ovf;

  int total = 0, bad = 0;
  int nlog = 0, eos0 = 0, eos1 = 0;
  logic [3:0]  log_ch [256];
  logic        log_pr [256];
  logic [11:0] log_a  [256];
  logic [11:0] log_b  [256];
  logic [7:0]  seqno = 8'd0;
  bit          done_flag = 1'b0;

  adc_seq_ctrl u_dut (.*);

  always #10 clk = ~clk;

  // behavioural converter: start seen at a falling edge, done two falling edges later
  initial begin
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_start) begin
        log_ch[nlog] = conv_chan;
        log_pr[nlog] = conv_pair;
        log_a[nlog]  = {conv_chan, seqno};
        log_b[nlog]  = ~{conv_chan, seqno};
        seqno = seqno + 8'd1;
        repeat (2) @(negedge clk);
        conv_data_a = log_a[nlog];
        conv_data_b = log_b[nlog];
        nlog = nlog + 1;
        conv_done = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (eos_pulse[0]) eos0 = eos0 + 1;
    if (eos_pulse[1]) eos1 = eos1 + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lft(input int i);
    return res_left[i*16 +: 16];
  endfunction
  function automatic logic [15:0] rgt(input int i);
    return res_right[i*16 +: 16];
  endfunction

  task automatic set_slot(input int i, input logic [3:0] ch);
    slot_chan[i*4 +: 4] = ch;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_eos(input int which, input int target);
    for (int k = 0; k < 400; k++) begin
      if ((which == 0 ? eos0 : eos1) >= target) break;
      cyc(1);
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 2'b11;
    @(negedge clk); irq_clr = 2'b00;
    #1;
  endtask

  task automatic t_reset();
    chk(conv_start == 1'b0, "R13 start idle", 32'(conv_start), 0);
    chk(irq_flag == 2'b00 && irq_ovf == 2'b00, "R13 flags", {irq_flag, irq_ovf}, 0);
    chk(res_left == '0 && res_right == '0, "R13 results", lft(0), 0);
  endtask

  task automatic t_dual_seq1();
    int b = nlog, e = eos0;
    logic [3:0] prog [4] = '{4'd3, 4'd3, 4'd9, 4'd0};
    for (int i = 0; i < 4; i++) set_slot(i, prog[i]);
    cnt_max1 = 4'd3;
    @(negedge clk); seq1_trig = 4'b0010;
    @(negedge clk); seq1_trig = 4'b0000;
    cyc(4);
    @(negedge clk); seq1_trig = 4'b0100;   // busy: ignored
    @(negedge clk); seq1_trig = 4'b0000;
    wait_eos(0, e + 1);
    cyc(30);
    chk(nlog - b == 4, "R1 R2 R7 conversions", 32'(nlog - b), 4);
    chk(eos0 - e == 1, "R8 eos once", 32'(eos0 - e), 1);
    for (int i = 0; i < 4; i++) begin
      chk(log_ch[b+i] == prog[i], "R5 channel", 32'(log_ch[b+i]), 32'(prog[i]));
      chk(lft(i) == {log_a[b+i], 4'h0}, "R1 R6 left", 32'(lft(i)), 32'({log_a[b+i], 4'h0}));
      chk(rgt(i) == {4'h0, log_a[b+i]}, "R6 right", 32'(rgt(i)), 32'({4'h0, log_a[b+i]}));
    end
    chk(irq_flag[0] == 1'b1, "R12 flag set", 32'(irq_flag), 1);
    clear_irq();
    chk(irq_flag == 2'b00, "R12 flag clear", 32'(irq_flag), 0);
  endtask

  task automatic t_min_seq2();
    int b = nlog, e = eos1;
    set_slot(8, 4'd12);
    cnt_max2 = 3'd0;
    @(negedge clk); seq2_trig = 2'b01;
    @(negedge clk); seq2_trig = 2'b00;
    wait_eos(1, e + 1);
    cyc(10);
    chk(nlog - b == 1, "R2 single conversion", 32'(nlog - b), 1);
    chk(log_ch[b] == 4'd12, "R4 slot 8 channel", 32'(log_ch[b]), 12);
    chk(rgt(8) == {4'h0, log_a[b]}, "R4 result reg 8", 32'(rgt(8)), 32'(log_a[b]));
    chk(irq_flag == 2'b10, "R12 flag seq2", 32'(irq_flag), 2);
    // second end of sequence before clearing
    @(negedge clk); seq2_trig = 2'b10;
    @(negedge clk); seq2_trig = 2'b00;
    wait_eos(1, e + 2);
    cyc(3);
    chk(irq_ovf[1] == 1'b1, "R12 overflow", 32'(irq_ovf), 2);
    clear_irq();
    chk(irq_ovf == 2'b00 && irq_flag == 2'b00, "R12 overflow clear", {irq_flag, irq_ovf}, 0);
  endtask

  task automatic t_arb();
    int b = nlog, e0 = eos0, e1 = eos1;
    set_slot(0, 4'd1); set_slot(1, 4'd2); set_slot(8, 4'd13); set_slot(9, 4'd14);
    cnt_max1 = 4'd1; cnt_max2 = 3'd1;
    @(negedge clk); seq1_trig = 4'b0001; seq2_trig = 2'b10;
    @(negedge clk); seq1_trig = 4'b0000; seq2_trig = 2'b00;
    wait_eos(1, e1 + 1);
    cyc(10);
    chk(nlog - b == 4, "R11 count", 32'(nlog - b), 4);
    chk(log_ch[b] == 4'd1 && log_ch[b+1] == 4'd2, "R11 seq1 first", {log_ch[b], log_ch[b+1]}, 32'h12);
    chk(log_ch[b+2] == 4'd13 && log_ch[b+3] == 4'd14, "R11 seq2 after", {log_ch[b+2], log_ch[b+3]}, 32'hDE);
    chk(rgt(9) == {4'h0, log_a[b+3]}, "R4 reg 9", 32'(rgt(9)), 32'(log_a[b+3]));
    chk(eos0 - e0 == 1, "R8 seq1 eos", 32'(eos0 - e0), 1);
    clear_irq();
  endtask

  task automatic t_cascade();
    int b = nlog, e0 = eos0, e1 = eos1;
    cascade = 1'b1;
    for (int i = 0; i < 10; i++) set_slot(i, 4'(15 - i));
    cnt_max1 = 4'd9;
    @(negedge clk); seq1_trig = 4'b1000;
    @(negedge clk); seq1_trig = 4'b0000; seq2_trig = 2'b01;
    @(negedge clk); seq2_trig = 2'b00;
    wait_eos(0, e0 + 1);
    cyc(30);
    chk(nlog - b == 10, "R3 ten slots", 32'(nlog - b), 10);
    chk(eos1 == e1, "R3 no seq2 eos", 32'(eos1 - e1), 0);
    for (int i = 0; i < 10; i++)
      chk(log_ch[b+i] == 4'(15 - i) && rgt(i) == {4'h0, log_a[b+i]}, "R3 slot result",
          32'(rgt(i)), 32'(log_a[b+i]));
    cascade = 1'b0;
    clear_irq();
  endtask

  task automatic t_paired();
    int b = nlog, e = eos0;
    pair_mode = 1'b1;
    set_slot(0, 4'd5); set_slot(1, 4'd10); set_slot(2, 4'd2);
    cnt_max1 = 4'd2;
    @(negedge clk); seq1_trig = 4'b0001;
    @(negedge clk); seq1_trig = 4'b0000;
    wait_eos(0, e + 1);
    cyc(10);
    chk(nlog - b == 3, "R10 count", 32'(nlog - b), 3);
    chk(log_ch[b] == 4'd5 && log_ch[b+1] == 4'd2 && log_ch[b+2] == 4'd2 && log_pr[b],
        "R10 pair index", {log_ch[b], log_ch[b+1], log_ch[b+2]}, 32'h522);
    for (int i = 0; i < 3; i++) begin
      chk(rgt(2*i) == {4'h0, log_a[b+i]}, "R10 A result", 32'(rgt(2*i)), 32'(log_a[b+i]));
      chk(rgt(2*i+1) == {4'h0, log_b[b+i]}, "R10 B result", 32'(rgt(2*i+1)), 32'(log_b[b+i]));
    end
    pair_mode = 1'b0;
    clear_irq();
  endtask

  task automatic t_contin();
    int b = nlog, e = eos0;
    run_cont = 1'b1;
    cnt_max1 = 4'd1;
    @(negedge clk); seq1_trig = 4'b0001;
    @(negedge clk); seq1_trig = 4'b0000;
    for (int k = 0; k < 400; k++) begin
      if (eos0 >= e + 3) break;
      @(negedge clk); #1;
    end
    run_cont = 1'b0;
    cyc(40);
    chk(nlog - b == 6, "R9 continuous runs", 32'(nlog - b), 6);
    chk(eos0 - e == 3, "R9 stop after clear", 32'(eos0 - e), 3);
    clear_irq();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done_flag) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(4);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    t_dual_seq1();
    t_min_seq2();
    t_arb();
    t_cascade();
    t_paired();
    t_contin();
    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule